// File: doc/BRIEF.md
# Floating-Point Flag Check Branch Unit

This unit resolves a conditional branch that depends on floating-point exception flags. A 2-bit selector picks one of four status fields, each holding its own group of flag bits. The chosen group is compared with two things: the trap-disable field and the flags already recorded in status field 0. The branch condition is true if a raised flag in the chosen group has its trap enabled, or if that flag has not yet been recorded in field 0. The whole check is gated by a qualifying predicate bit.

When the condition holds and branching is enabled, the unit produces the target address. The 21-bit displacement counts 16-byte bundles, so it is shifted left by four, sign-extended, and added to the current instruction pointer. The unit also raises a taken-branch trap and an unimplemented-address trap when the trap conditions hold. When branching is disabled by configuration, the unit raises a speculation fault instead. With that fault it supplies the zero-extended displacement, which a handler uses to emulate the branch.

All results are registered and appear for one cycle, on the cycle after an issue strobe.

Top module: `fpflag_branch_unit`

## Requirements
- R1: During and directly after a synchronous active-low reset, all outputs are zero.
- R2: A result is a one-cycle pulse. In any cycle that follows a clock edge at which `issue` was low, `taken`, `spec_fault`, `tb_trap` and `uia_trap` are all 0.
- R3: When `pred` is 0 at issue, no branch, fault or trap is reported, whatever the flags are.
- R4: Field k's flag group occupies bits [6k+5:6k] of `fld_flags`, and `sel` chooses k. The condition is true when (chosen & ~`trap_dis`) or (chosen & ~field0) is nonzero. Groups that are not chosen have no effect.
- R5: When the condition holds and `branch_impl` is 1, `taken` is 1 and `next_ip` = `ip` + sign-extend({`disp`, 4'b0000}) modulo 2^64. `ip` is expected to have its low 4 bits zero.
- R6: When the condition holds and `branch_impl` is 0, `spec_fault` is 1, `taken` is 0, both traps are 0, and `iim_value` is `disp` zero-extended to 64 bits.
- R7: `tb_trap` is 1 exactly when a branch is taken and `psr_tb` was 1.
- R8: `uia_trap` is 1 exactly when all of the following hold: a branch is taken, `uia_fault_ok` was 0, and the target was flagged unimplemented. `va_unimpl` is used when `psr_it` is 1, and `pa_unimpl` when it is 0.
- R9: `taken` and `spec_fault` are never 1 together. When the condition is false, both are 0.
- R10: `next_ip` is zero whenever `taken` is 0, and `iim_value` is zero whenever `spec_fault` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue | input | 1 | Evaluate the check this cycle |
| pred | input | 1 | Qualifying predicate |
| sel | input | 2 | Status field selector |
| fld_flags | input | 24 | Four 6-bit flag groups, field k at [6k+5:6k] |
| trap_dis | input | 6 | Trap-disable bits |
| ip | input | 64 | Address of the current bundle |
| disp | input | 21 | Signed bundle displacement |
| branch_impl | input | 1 | 1: branch in hardware, 0: raise fault |
| psr_tb | input | 1 | Taken-branch trap enable |
| psr_it | input | 1 | Translation on: use virtual-address check |
| uia_fault_ok | input | 1 | Unimplemented addresses are reported as faults elsewhere |
| va_unimpl | input | 1 | Target virtual address is unimplemented |
| pa_unimpl | input | 1 | Target physical address is unimplemented |
| taken | output | 1 | Branch taken |
| next_ip | output | 64 | Branch target |
| spec_fault | output | 1 | Speculation fault instead of branch |
| iim_value | output | 64 | Zero-extended displacement for the handler |
| tb_trap | output | 1 | Taken-branch trap |
| uia_trap | output | 1 | Unimplemented-address trap |

## Verification
The hardest case to reach is one where only the second term of the condition fires. The chosen field must carry a flag whose trap is disabled but which field 0 has not recorded. The stimulus builds this with all trap-disable bits set, a flag in field 1 and an empty field 0. A mirror case sets the trap-disable bits to zero so that only the first term can fire. Address wraparound is also forced from the ports, using a zero `ip` and a negative displacement, and then the most positive and most negative displacements.

// File: rtl/fpchk_pkg.sv
// Shared types for the flag-check branch unit.
package fpchk_pkg;
    // Event flags produced by one evaluation.
    typedef struct packed {
        logic taken;
        logic spec_fault;
        logic tb_trap;
        logic uia_trap;
    } fpc_evt_t;
endpackage

// File: rtl/fpc_flag_mux.sv
// Splits the packed flag vector into groups and selects one of them.
// Also exposes group 0, which serves as the record of flags already seen.
// Assumes NUM_FLD <= 2**SEL_W.
module fpc_flag_mux #(
    parameter int FLAG_W  = 6,
    parameter int NUM_FLD = 4,
    parameter int SEL_W   = $clog2(NUM_FLD)
) (
    input  logic [NUM_FLD*FLAG_W-1:0] all_flags,
    input  logic [SEL_W-1:0]          sel,
    output logic [FLAG_W-1:0]         sel_flags,
    output logic [FLAG_W-1:0]         base_flags
);
    logic [FLAG_W-1:0] grp [NUM_FLD];

    // Unpack each field's flag group.
    for (genvar g = 0; g < NUM_FLD; g++) begin : g_split
        assign grp[g] = all_flags[g*FLAG_W +: FLAG_W];
    end

    // Select the group to check; group 0 is the baseline.
    always_comb begin
        sel_flags  = grp[sel];
        base_flags = grp[0];
    end
endmodule

// File: rtl/fpc_cond.sv
// Evaluates the check condition: a raised flag that is trap-enabled,
// or a raised flag that is not yet recorded in the baseline group.
module fpc_cond #(
    parameter int FLAG_W = 6
) (
    input  logic [FLAG_W-1:0] sel_flags,
    input  logic [FLAG_W-1:0] base_flags,
    input  logic [FLAG_W-1:0] trap_dis,
    output logic              hit
);
    logic [FLAG_W-1:0] enabled_hits;
    logic [FLAG_W-1:0] new_hits;

    // Combine both reasons for leaving the fast path.
    always_comb begin
        enabled_hits = sel_flags & ~trap_dis;
        new_hits     = sel_flags & ~base_flags;
        hit          = (|enabled_hits) | (|new_hits);
    end
endmodule

// File: rtl/fpc_target.sv
// Computes the bundle-relative branch target and the zero-extended
// immediate for the fault path. Wraps modulo 2**IP_W.
module fpc_target #(
    parameter int IP_W   = 64,
    parameter int DISP_W = 21,
    parameter int SH     = 4,
    parameter int IIM_W  = 64
) (
    input  logic [IP_W-1:0]   ip,
    input  logic [DISP_W-1:0] disp,
    output logic [IP_W-1:0]   target,
    output logic [IIM_W-1:0]  iim
);
    localparam int OFF_W = DISP_W + SH;

    logic [IP_W-1:0] offset;

    // Sign-extend the bundle-scaled offset and add it.
    always_comb begin
        offset = {{(IP_W-OFF_W){disp[DISP_W-1]}}, disp, {SH{1'b0}}};
        target = ip + offset;
        iim    = {{(IIM_W-DISP_W){1'b0}}, disp};
    end
endmodule

// File: rtl/fpc_trap_eval.sv
// Decides which traps a taken branch would raise. The caller
// qualifies the results with the taken decision.
module fpc_trap_eval (
    input  logic psr_tb,
    input  logic psr_it,
    input  logic uia_fault_ok,
    input  logic va_unimpl,
    input  logic pa_unimpl,
    output logic tb_hit,
    output logic uia_hit
);
    logic addr_bad;

    // Pick the address check matching the translation mode.
    always_comb begin
        addr_bad = psr_it ? va_unimpl : pa_unimpl;
        tb_hit   = psr_tb;
        uia_hit  = addr_bad & ~uia_fault_ok;
    end
endmodule

// File: rtl/fpflag_branch_unit.sv
// Top of the flag-check branch unit. Evaluates on issue, registers all
// results, and presents them for one cycle. Assumes ip is bundle aligned.
module fpflag_branch_unit
    import fpchk_pkg::*;
#(
    parameter int FLAG_W  = 6,
    parameter int NUM_FLD = 4,
    parameter int IP_W    = 64,
    parameter int DISP_W  = 21,
    parameter int IIM_W   = 64,
    localparam int SEL_W  = $clog2(NUM_FLD),
    localparam int ALL_W  = NUM_FLD * FLAG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic              pred,
    input  logic [SEL_W-1:0]  sel,
    input  logic [ALL_W-1:0]  fld_flags,
    input  logic [FLAG_W-1:0] trap_dis,
    input  logic [IP_W-1:0]   ip,
    input  logic [DISP_W-1:0] disp,
    input  logic              branch_impl,
    input  logic              psr_tb,
    input  logic              psr_it,
    input  logic              uia_fault_ok,
    input  logic              va_unimpl,
    input  logic              pa_unimpl,
    output logic              taken,
    output logic [IP_W-1:0]   next_ip,
    output logic              spec_fault,
    output logic [IIM_W-1:0]  iim_value,
    output logic              tb_trap,
    output logic              uia_trap
);
    localparam int BUNDLE_SH = 4;

    logic [FLAG_W-1:0] sel_flags, base_flags;
    logic              hit, tb_hit, uia_hit;
    logic [IP_W-1:0]   target;
    logic [IIM_W-1:0]  iim;
    fpc_evt_t          evt_d, evt_q;
    logic [IP_W-1:0]   ip_d;
    logic [IIM_W-1:0]  iim_d;

    fpc_flag_mux #(.FLAG_W(FLAG_W), .NUM_FLD(NUM_FLD), .SEL_W(SEL_W)) u_mux (
        .all_flags (fld_flags),
        .sel       (sel),
        .sel_flags (sel_flags),
        .base_flags(base_flags)
    );

    fpc_cond #(.FLAG_W(FLAG_W)) u_cond (
        .sel_flags (sel_flags),
        .base_flags(base_flags),
        .trap_dis  (trap_dis),
        .hit       (hit)
    );

    fpc_target #(.IP_W(IP_W), .DISP_W(DISP_W), .SH(BUNDLE_SH), .IIM_W(IIM_W)) u_tgt (
        .ip    (ip),
        .disp  (disp),
        .target(target),
        .iim   (iim)
    );

    fpc_trap_eval u_trap (
        .psr_tb      (psr_tb),
        .psr_it      (psr_it),
        .uia_fault_ok(uia_fault_ok),
        .va_unimpl   (va_unimpl),
        .pa_unimpl   (pa_unimpl),
        .tb_hit      (tb_hit),
        .uia_hit     (uia_hit)
    );

    // Resolve branch versus fault and qualify the traps.
    always_comb begin
        logic go;
        go               = issue & pred & hit;
        evt_d.taken      = go & branch_impl;
        evt_d.spec_fault = go & ~branch_impl;
        evt_d.tb_trap    = evt_d.taken & tb_hit;
        evt_d.uia_trap   = evt_d.taken & uia_hit;
        ip_d             = evt_d.taken ? target : '0;
        iim_d            = evt_d.spec_fault ? iim : '0;
    end

    // Register the result for one cycle; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_q     <= '0;
            next_ip   <= '0;
            iim_value <= '0;
        end else begin
            evt_q     <= evt_d;
            next_ip   <= ip_d;
            iim_value <= iim_d;
        end
    end

    assign taken      = evt_q.taken;
    assign spec_fault = evt_q.spec_fault;
    assign tb_trap    = evt_q.tb_trap;
    assign uia_trap   = evt_q.uia_trap;
endmodule

// File: rtl/fpc_chk.sv
// Property checker for the flag-check branch unit, bound to the top.
module fpc_chk #(
    parameter int IP_W   = 64,
    parameter int DISP_W = 21,
    parameter int IIM_W  = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             issue,
    input logic             pred,
    input logic             branch_impl,
    input logic             taken,
    input logic [IP_W-1:0]  next_ip,
    input logic             spec_fault,
    input logic [IIM_W-1:0] iim_value,
    input logic             tb_trap,
    input logic             uia_trap
);
    // R9
    excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(taken && spec_fault));
    // R7
    tb_needs_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tb_trap |-> taken);
    // R8
    uia_needs_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uia_trap |-> taken);
    // R10
    ip_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !taken |-> next_ip == '0);
    // R10
    iim_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !spec_fault |-> iim_value == '0);
    // R3
    pred_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && !pred) |=> (!taken && !spec_fault && !tb_trap && !uia_trap));
    // R2
    pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !issue |=> (!taken && !spec_fault && !tb_trap && !uia_trap));
    // R6
    no_branch_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && !branch_impl) |=> !taken);
    // R6
    iim_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spec_fault |-> iim_value[IIM_W-1:DISP_W] == '0);
    // R5
    target_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        taken |-> next_ip[3:0] == 4'h0);
endmodule

bind fpflag_branch_unit fpc_chk #(.IP_W(IP_W), .DISP_W(DISP_W), .IIM_W(IIM_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .issue      (issue),
    .pred       (pred),
    .branch_impl(branch_impl),
    .taken      (taken),
    .next_ip    (next_ip),
    .spec_fault (spec_fault),
    .iim_value  (iim_value),
    .tb_trap    (tb_trap),
    .uia_trap   (uia_trap)
);

// File: tb/fpflag_branch_unit_tb.sv
// Directed bench: one task per scenario, each checking its own results.
module fpflag_branch_unit_tb;
    localparam int CLK_P = 10;

    logic        clk = 0;
    logic        rst_n;
    logic        issue, pred;
    logic [1:0]  sel;
    logic [23:0] fld_flags;
    logic [5:0]  trap_dis;
    logic [63:0] ip;
    logic [20:0] disp;
    logic        branch_impl, psr_tb, psr_it, uia_fault_ok, va_unimpl, pa_unimpl;
    logic        taken, spec_fault, tb_trap, uia_trap;
    logic [63:0] next_ip, iim_value;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    fpflag_branch_unit u_dut (
        .clk(clk), .rst_n(rst_n), .issue(issue), .pred(pred), .sel(sel),
        .fld_flags(fld_flags), .trap_dis(trap_dis), .ip(ip), .disp(disp),
        .branch_impl(branch_impl), .psr_tb(psr_tb), .psr_it(psr_it),
        .uia_fault_ok(uia_fault_ok), .va_unimpl(va_unimpl), .pa_unimpl(pa_unimpl),
        .taken(taken), .next_ip(next_ip), .spec_fault(spec_fault),
        .iim_value(iim_value), .tb_trap(tb_trap), .uia_trap(uia_trap)
    );

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Compare every output against the expected set.
    task automatic chk_all(string req, bit e_tk, bit e_sf, bit e_tb, bit e_ua,
                           logic [63:0] e_ip, logic [63:0] e_iim);
        chk({req, " flags"}, {60'd0, taken, spec_fault, tb_trap, uia_trap},
            {60'd0, e_tk, e_sf, e_tb, e_ua});
        chk({req, " next_ip"}, next_ip, e_ip);
        chk({req, " iim"}, iim_value, e_iim);
    endtask

    task automatic defaults();
        issue = 0; pred = 1; sel = 0; fld_flags = '0; trap_dis = '0;
        ip = 64'h1_0000; disp = '0; branch_impl = 1; psr_tb = 0; psr_it = 0;
        uia_fault_ok = 0; va_unimpl = 0; pa_unimpl = 0;
    endtask

    // Issue one evaluation with the current inputs; return at the sampling point.
    task automatic fire();
        issue = 1;
        @(posedge clk);
        @(negedge clk);
        issue = 0;
    endtask

    task automatic t_reset();
        rst_n = 0; defaults(); issue = 1; fld_flags = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk_all("R1 in reset", 0, 0, 0, 0, 0, 0);
        issue = 0; rst_n = 1;
        @(posedge clk); @(negedge clk);
        chk_all("R1 after reset", 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_first_term();
        defaults(); sel = 2; fld_flags[17:12] = 6'b000100; fld_flags[5:0] = 6'b000100;
        disp = 21'h10;
        fire();
        chk_all("R4 R5 enabled trap", 1, 0, 0, 0, 64'h1_0100, 0);
        @(posedge clk); @(negedge clk);
        chk_all("R2 pulse ends", 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_second_term();
        defaults(); sel = 1; fld_flags[11:6] = 6'b100000; trap_dis = 6'b111111;
        ip = 64'h1000; disp = 21'h1FFFFF;
        fire();
        chk_all("R4 R5 unrecorded flag", 1, 0, 0, 0, 64'hFF0, 0);
    endtask

    task automatic t_no_cond();
        defaults(); sel = 3; fld_flags[23:18] = 6'b001010; fld_flags[5:0] = 6'b001010;
        trap_dis = 6'b111111; disp = 21'h55;
        fire();
        chk_all("R9 R10 no condition", 0, 0, 0, 0, 0, 0);
        defaults(); sel = 0; fld_flags[5:0] = 6'b000001; trap_dis = 6'b000001;
        fire();
        chk_all("R4 field0 disabled", 0, 0, 0, 0, 0, 0);
        trap_dis = 6'b000000; disp = 21'h2;
        fire();
        chk_all("R4 field0 enabled", 1, 0, 0, 0, 64'h1_0020, 0);
        defaults(); sel = 1; fld_flags = 24'hFFF03F;
        fire();
        chk_all("R4 unselected ignored", 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_wrap();
        defaults(); sel = 2; fld_flags[17:12] = 6'b000001; ip = 64'h0; disp = 21'h1FFFFF;
        fire();
        chk_all("R5 wrap below zero", 1, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFF0, 0);
        ip = 64'h10; disp = 21'h0FFFFF;
        fire();
        chk_all("R5 max forward", 1, 0, 0, 0, 64'h100_0000, 0);
        ip = 64'h200_0000; disp = 21'h100000;
        fire();
        chk_all("R5 max backward", 1, 0, 0, 0, 64'h100_0000, 0);
    endtask

    task automatic t_fault();
        defaults(); sel = 2; fld_flags[17:12] = 6'b010000; branch_impl = 0;
        disp = 21'h1ABCDE; psr_tb = 1; psr_it = 1; va_unimpl = 1;
        fire();
        chk_all("R6 speculation fault", 0, 1, 0, 0, 0, 64'h1A_BCDE);
    endtask

    task automatic t_pred_off();
        defaults(); pred = 0; sel = 2; fld_flags = '1; psr_tb = 1; disp = 21'h4;
        fire();
        chk_all("R3 predicate off", 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_traps();
        defaults(); sel = 2; fld_flags[17:12] = 6'b000010; disp = 21'h1;
        psr_tb = 1;
        fire();
        chk_all("R7 taken-branch trap", 1, 0, 1, 0, 64'h1_0010, 0);
        psr_tb = 0; psr_it = 1; va_unimpl = 1;
        fire();
        chk_all("R8 virtual unimpl", 1, 0, 0, 1, 64'h1_0010, 0);
        psr_it = 0;
        fire();
        chk_all("R8 physical ok", 1, 0, 0, 0, 64'h1_0010, 0);
        va_unimpl = 0; pa_unimpl = 1;
        fire();
        chk_all("R8 physical unimpl", 1, 0, 0, 1, 64'h1_0010, 0);
        uia_fault_ok = 1;
        fire();
        chk_all("R8 fault reporting", 1, 0, 0, 0, 64'h1_0010, 0);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_first_term();
                t_second_term();
                t_no_cond();
                t_wrap();
                t_fault();
                t_pred_off();
                t_traps();
                done = 1;
            end
            begin
                repeat (5000) @(posedge clk);
                if (!done) begin
                    n_chk++; n_bad++;
                    $display("FAIL watchdog: actual hung expected done");
                end
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule